// File: doc/BRIEF.md
# Interrupt Distributor with Per-Line Level or Edge Trigger

This block collects a set of synchronous peripheral interrupt lines and serves them to one processor through a single IRQ output. Every line has a two-bit trigger configuration, an enable bit, an 8-bit priority, and its own pending and active state. The block selects the best candidate: a line that is pending, enabled and not active, with the lowest priority value. IRQ is raised while such a candidate exists and the global enable is set.

Software reaches the block through a word-addressed register port. Writes are strobed. Reads return data combinationally for the address on the port, and an acknowledge read also changes state on the clock edge where the read strobe is high. The two trigger modes differ in how a line stops being pending. An edge-triggered line stays pending until it is acknowledged or cleared by software. A level-sensitive line is pending exactly while its input is high. An acknowledge does not clear it, and IRQ falls when its input falls.

Top module: `irq_dist`

## Requirements
- R1: Line n has a two-bit trigger field at bits 2(n mod 16)+1 : 2(n mod 16) of configuration word 8 + n/16. The line is edge-triggered when the upper bit of the field is 1 and level-sensitive when it is 0. Reads of those words return the fields as written.
- R2: An edge-triggered line becomes pending on a rising edge of its input, and a later fall of the input changes nothing.
- R3: A read of word 4 (acknowledge) returns the ID of the best candidate: pending, enabled (word 1, one bit per line) and not active, with the lowest priority value. Ties go to the lowest ID. The read returns 1023 when there is no candidate. The priority of line n is in bits 8(n mod 4)+7 : 8(n mod 4) of word 16 + n/4.
- R4: An acknowledge of a line sets its active bit (word 6 reads the active bits). It clears the pending bit only if the line is edge-triggered; a level-sensitive line stays pending.
- R5: A level-sensitive line's pending bit follows its input one clock later. Writes to word 2 (set-pending) and word 3 (clear-pending) leave it unchanged. Reads of words 2 and 3 return the pending bits.
- R6: When a level-sensitive input falls, its pending bit clears at the next edge. If no candidate is left, IRQ drops one edge after that.
- R7: Writing an ID to word 5 (end-of-interrupt) clears that line's active bit. A level-sensitive line whose input is still high then raises IRQ again.
- R8: For edge-triggered lines, writing a 1 to a bit of word 2 sets that line's pending bit, and writing a 1 to a bit of word 3 clears it.
- R9: When the candidate set becomes empty and the previous selection was edge-triggered, IRQ is held until an acknowledge read. The spurious ID 1023 is never treated as level-sensitive.
- R10: Bit 0 of word 0 is the global enable. While it is 0, IRQ is low, although the pending state still updates.
- R11: After reset, IRQ is low, every register reads 0 (so every line is level-sensitive), and the acknowledge word returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Interrupt inputs, one per line, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the acknowledge side effect) |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The inputs are driven as a single-cycle pulse, as a level held high across the acknowledge and end-of-interrupt, and as a level that falls. The pulse shows whether the block remembers an edge. The held level shows whether an acknowledge wrongly clears a level line's pending bit, and the falling level shows whether the block drops IRQ on withdrawal. Two lines with different priorities and then equal priorities separate priority order from ID order. Set-pending and clear-pending writes are sent to both kinds of line, which shows that only edge lines accept them. Clearing the pending bit of an edge line checks that IRQ is held until an acknowledge, and not dropped as if the spurious ID were level-sensitive.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ID_W   = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int CFG_PER_WORD = DATA_W / 2;

  localparam logic [ADDR_W-1:0] RA_CTRL      = 6'd0;
  localparam logic [ADDR_W-1:0] RA_ENABLE    = 6'd1;
  localparam logic [ADDR_W-1:0] RA_SETPEND   = 6'd2;
  localparam logic [ADDR_W-1:0] RA_CLRPEND   = 6'd3;
  localparam logic [ADDR_W-1:0] RA_ACK       = 6'd4;
  localparam logic [ADDR_W-1:0] RA_EOI       = 6'd5;
  localparam logic [ADDR_W-1:0] RA_ACTIVE    = 6'd6;
  localparam int                RA_CFG_BASE  = 8;
  localparam int                RA_PRIO_BASE = 16;

  // Trigger-mode decode; the spurious ID never counts as level-sensitive.
  function automatic logic field_is_level(input logic [ID_W-1:0] id,
                                          input logic [1:0] field);
    return (id != SPURIOUS_ID) && !field[1];
  endfunction
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic                      gen_en,
  output logic [NUM_IRQ-1:0]        enable,
  output logic [2*NUM_IRQ-1:0]      cfg,
  output logic [NUM_IRQ*PRIO_W-1:0] prio,
  output logic [NUM_IRQ-1:0]        set_w,
  output logic [NUM_IRQ-1:0]        clr_w,
  output logic                      eoi_w,
  output logic [ID_W-1:0]           eoi_id
);
  localparam int PRIO_PER_WORD = DATA_W / PRIO_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      enable <= '0;
    end else if (wr) begin
      if (addr == RA_CTRL)   gen_en <= wdata[0];
      if (addr == RA_ENABLE) enable <= wdata[NUM_IRQ-1:0];
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line_regs
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(RA_CFG_BASE + i / CFG_PER_WORD);
    localparam logic [ADDR_W-1:0] PRIO_A = ADDR_W'(RA_PRIO_BASE + i / PRIO_PER_WORD);
    localparam int CFG_LSB  = 2 * (i % CFG_PER_WORD);
    localparam int PRIO_LSB = PRIO_W * (i % PRIO_PER_WORD);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[2*i +: 2]          <= 2'b00;
        prio[i*PRIO_W +: PRIO_W] <= '0;
      end else if (wr) begin
        if (addr == CFG_A)  cfg[2*i +: 2] <= wdata[CFG_LSB +: 2];
        if (addr == PRIO_A) prio[i*PRIO_W +: PRIO_W] <= wdata[PRIO_LSB +: PRIO_W];
      end
    end
  end

  assign set_w  = (wr && addr == RA_SETPEND) ? wdata[NUM_IRQ-1:0] : '0;
  assign clr_w  = (wr && addr == RA_CLRPEND) ? wdata[NUM_IRQ-1:0] : '0;
  assign eoi_w  = wr && (addr == RA_EOI);
  assign eoi_id = wdata[ID_W-1:0];
endmodule

// File: rtl/irqd_line.sv
module irqd_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic level,
  input  logic set_w,
  input  logic clr_w,
  input  logic ack_take,
  input  logic eoi_take,
  output logic rise,
  output logic pending,
  output logic active
);
  logic in_q;

  assign rise = irq_in && !in_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      pending <= 1'b0;
      active  <= 1'b0;
    end else begin
      in_q <= irq_in;
      if (level) pending <= irq_in;
      else       pending <= (pending && !clr_w && !ack_take) || rise || set_w;
      active <= (active || ack_take) && !eoi_take;
    end
  end
endmodule

// File: rtl/irqd_select.sv
module irqd_select
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_IRQ-1:0]        cand,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  output logic                      valid,
  output logic [ID_W-1:0]           id
);
  logic [PRIO_W-1:0] best_p;

  // Strict compare keeps the lower ID on equal priority.
  always_comb begin
    valid  = 1'b0;
    id     = SPURIOUS_ID;
    best_p = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!valid || prio[i*PRIO_W +: PRIO_W] < best_p)) begin
        valid  = 1'b1;
        id     = ID_W'(i);
        best_p = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [5:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_out
);
  localparam int CFG_WORDS  = (2 * NUM_IRQ + DATA_W - 1) / DATA_W;
  localparam int PRIO_WORDS = (NUM_IRQ * PRIO_W + DATA_W - 1) / DATA_W;

  logic                      gen_en;
  logic [NUM_IRQ-1:0]        enable, set_w, clr_w, rise, pending, active;
  logic [NUM_IRQ-1:0]        level_mask, ack_take, eoi_take;
  logic [2*NUM_IRQ-1:0]      cfg;
  logic [NUM_IRQ*PRIO_W-1:0] prio;
  logic                      eoi_w;
  logic [ID_W-1:0]           eoi_id;
  logic                      best_valid;
  logic [ID_W-1:0]           best_id;
  logic [ID_W-1:0]           sel_prev;
  logic                      prev_level;
  logic                      ack_fire, ack_q;
  logic [CFG_WORDS*DATA_W-1:0]  cfg_pad;
  logic [PRIO_WORDS*DATA_W-1:0] prio_pad;

  irqd_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .gen_en(gen_en), .enable(enable), .cfg(cfg), .prio(prio),
    .set_w(set_w), .clr_w(clr_w), .eoi_w(eoi_w), .eoi_id(eoi_id)
  );

  assign ack_fire = reg_rd && (reg_addr == RA_ACK);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign level_mask[i] = field_is_level(ID_W'(i), cfg[2*i +: 2]);
    assign ack_take[i]   = ack_fire && best_valid && (best_id == ID_W'(i));
    assign eoi_take[i]   = eoi_w && (eoi_id == ID_W'(i));
    irqd_line line_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in[i]), .level(level_mask[i]),
      .set_w(set_w[i]), .clr_w(clr_w[i]), .ack_take(ack_take[i]),
      .eoi_take(eoi_take[i]), .rise(rise[i]), .pending(pending[i]),
      .active(active[i])
    );
  end

  irqd_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) sel_i (
    .cand(pending & enable & ~active), .prio(prio),
    .valid(best_valid), .id(best_id)
  );

  // Trigger mode of the previous selection; spurious decodes as not level.
  always_comb begin
    prev_level = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (sel_prev == ID_W'(i)) prev_level = field_is_level(sel_prev, cfg[2*i +: 2]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_prev <= SPURIOUS_ID;
      ack_q    <= 1'b0;
      irq_out  <= 1'b0;
    end else begin
      sel_prev <= best_valid ? best_id : SPURIOUS_ID;
      ack_q    <= ack_fire;
      if (!gen_en)                irq_out <= 1'b0;
      else if (best_valid)        irq_out <= 1'b1;
      else if (prev_level)        irq_out <= 1'b0;
      else if (ack_fire || ack_q) irq_out <= 1'b0;
    end
  end

  assign cfg_pad  = {{(CFG_WORDS*DATA_W - 2*NUM_IRQ){1'b0}}, cfg};
  assign prio_pad = {{(PRIO_WORDS*DATA_W - NUM_IRQ*PRIO_W){1'b0}}, prio};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:                reg_rdata[0] = gen_en;
      RA_ENABLE:              reg_rdata[NUM_IRQ-1:0] = enable;
      RA_SETPEND, RA_CLRPEND: reg_rdata[NUM_IRQ-1:0] = pending;
      RA_ACK:                 reg_rdata[ID_W-1:0] = best_id;
      RA_ACTIVE:              reg_rdata[NUM_IRQ-1:0] = active;
      default: begin
        for (int w = 0; w < CFG_WORDS; w++)
          if (reg_addr == ADDR_W'(RA_CFG_BASE + w)) reg_rdata = cfg_pad[w*DATA_W +: DATA_W];
        for (int w = 0; w < PRIO_WORDS; w++)
          if (reg_addr == ADDR_W'(RA_PRIO_BASE + w)) reg_rdata = prio_pad[w*DATA_W +: DATA_W];
      end
    endcase
  end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_out,
  input logic               gen_en,
  input logic               best_valid,
  input logic [ID_W-1:0]    best_id,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic [NUM_IRQ-1:0] pending,
  input logic [NUM_IRQ-1:0] active,
  input logic [NUM_IRQ-1:0] enable,
  input logic [NUM_IRQ-1:0] level_mask,
  input logic [NUM_IRQ-1:0] ack_take,
  input logic [NUM_IRQ-1:0] eoi_take,
  input logic [NUM_IRQ-1:0] rise,
  input logic [NUM_IRQ-1:0] set_w
);
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  logic live_q;

  always_ff @(posedge clk) live_q <= rst_n;

  a_r10_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !irq_out);

  a_r3_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_take));

  a_r3_best_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> (pending[best_id[IW-1:0]] && enable[best_id[IW-1:0]]
                    && !active[best_id[IW-1:0]]));

  a_r4_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_take & ~eoi_take) != '0) |=> ((active & $past(ack_take)) != '0));

  a_r4_level_stays_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_take & level_mask & irq_in) != '0) |=> ((pending & $past(ack_take)) != '0));

  a_r4_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_take & ~level_mask & ~rise & ~set_w) != '0)
      |=> ((pending & $past(ack_take)) == '0));

  a_r5_level_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((pending & $past(level_mask)) == ($past(irq_in) & $past(level_mask))));
endmodule

bind irq_dist irq_dist_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .gen_en(gen_en),
  .best_valid(best_valid), .best_id(best_id), .irq_in(irq_in),
  .pending(pending), .active(active), .enable(enable),
  .level_mask(level_mask), .ack_take(ack_take), .eoi_take(eoi_take),
  .rise(rise), .set_w(set_w)
);

// File: tb/irq_dist_tb_top.sv
module irq_dist_tb_top;
  localparam int N = 32;
  localparam logic [5:0] A_CTRL = 6'd0, A_EN = 6'd1, A_SET = 6'd2, A_CLR = 6'd3,
                         A_ACK = 6'd4, A_EOI = 6'd5, A_ACT = 6'd6, A_CFG0 = 6'd8,
                         A_PRIO0 = 6'd16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_dist dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ack(output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = A_ACK; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 irq after reset", 32'(irq_out), 0);
    rd(A_ACK, d);  chk("R11 ack idle", d, 1023);
    rd(A_EN, d);   chk("R11 enable reset", d, 0);
    rd(A_CFG0, d); chk("R11 cfg reset", d, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(A_CFG0, 32'h0000_0280);            // lines 3 and 4 edge
    rd(A_CFG0, d); chk("R1 cfg readback", d, 32'h0000_0280);
    @(negedge clk) irq_in[3] = 1'b1;
    @(negedge clk) irq_in[3] = 1'b0;
    settle();
    rd(A_SET, d); chk("R2 edge pending after fall", d & 32'h8, 32'h8);
    chk("R2 irq raised", 32'(irq_out), 1);
    ack(d); chk("R3 ack edge id", d, 3);
    settle();
    rd(A_SET, d); chk("R4 edge pending cleared", d & 32'h8, 0);
    rd(A_ACT, d); chk("R4 active set", d & 32'h8, 32'h8);
    chk("R4 irq after edge ack", 32'(irq_out), 0);
    wr(A_EOI, 32'd3); settle();
    rd(A_ACT, d); chk("R7 eoi clears active", d & 32'h8, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk) irq_in[5] = 1'b1;
    settle();
    chk("R5 level irq", 32'(irq_out), 1);
    ack(d); chk("R3 ack level id", d, 5);
    settle();
    rd(A_SET, d); chk("R4 level stays pending", d & 32'h20, 32'h20);
    rd(A_ACT, d); chk("R4 level active", d & 32'h20, 32'h20);
    chk("R4 irq low while active", 32'(irq_out), 0);
    wr(A_EOI, 32'd5); settle();
    chk("R7 irq re-raised", 32'(irq_out), 1);
    @(negedge clk) irq_in[5] = 1'b0;
    @(negedge clk);
    chk("R6 irq one edge later", 32'(irq_out), 1);
    @(negedge clk);
    chk("R6 irq dropped", 32'(irq_out), 0);
    rd(A_SET, d); chk("R6 level pending cleared", d & 32'h20, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(A_PRIO0 + 6'd1, 32'h1000_0000);   // line 7 prio 0x10
    wr(A_PRIO0, 32'h0020_0000);          // line 2 prio 0x20
    @(negedge clk) begin irq_in[7] = 1'b1; irq_in[2] = 1'b1; end
    settle();
    ack(d); chk("R3 lower prio value wins", d, 7);
    ack(d); chk("R3 next candidate", d, 2);
    wr(A_EOI, 32'd7); wr(A_EOI, 32'd2);
    wr(A_PRIO0 + 6'd1, 0); wr(A_PRIO0, 0);
    settle();
    ack(d); chk("R3 tie lowest id", d, 2);
    wr(A_EOI, 32'd2);
    @(negedge clk) begin irq_in[7] = 1'b0; irq_in[2] = 1'b0; end
    settle();
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(A_CTRL, 0);
    @(negedge clk) irq_in[6] = 1'b1;
    settle();
    chk("R10 irq gated", 32'(irq_out), 0);
    rd(A_SET, d); chk("R10 pending still tracks", d & 32'h40, 32'h40);
    wr(A_CTRL, 1); settle();
    chk("R10 irq after enable", 32'(irq_out), 1);
    wr(A_EN, 32'hFFFF_FFBF); settle();
    rd(A_ACK, d); chk("R3 disabled line not offered", d, 1023);
    wr(A_EN, 32'hFFFF_FFFF);
    @(negedge clk) irq_in[6] = 1'b0;
    settle();
  endtask

  task automatic t_soft();
    logic [31:0] d;
    wr(A_SET, 32'h10); settle();
    rd(A_SET, d); chk("R8 set pending edge", d & 32'h10, 32'h10);
    chk("R8 irq from set", 32'(irq_out), 1);
    wr(A_CLR, 32'h10); settle(); settle();
    rd(A_CLR, d); chk("R8 clear pending edge", d & 32'h10, 0);
    chk("R9 irq held after edge clear", 32'(irq_out), 1);
    ack(d); chk("R9 ack returns spurious", d, 1023);
    settle();
    chk("R9 irq released by ack", 32'(irq_out), 0);
    wr(A_SET, 32'h200); settle();
    rd(A_SET, d); chk("R5 set ignored on level", d & 32'h200, 0);
    @(negedge clk) irq_in[9] = 1'b1;
    settle();
    wr(A_CLR, 32'h200); settle();
    rd(A_SET, d); chk("R5 clear ignored on level", d & 32'h200, 32'h200);
    @(negedge clk) irq_in[9] = 1'b0;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr(A_CTRL, 1);
    wr(A_EN, 32'hFFFF_FFFF);
    t_edge();
    t_level();
    t_prio();
    t_gate();
    t_soft();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule